// File: doc/BRIEF.md
# Overlay Window Hit Selector

This block sits between a display timing generator and a pixel blender. Every clock it takes the current screen coordinate and tests it against five rectangular overlay windows at once. From the enabled windows that cover the coordinate, it picks the one highest in the stack. For that window it reports the index, its red, green and blue blend factors and its colour-key enable. When no window covers the pixel, it reports a miss and passes a programmable background colour instead.

Each window is described by an origin, a width and a height, together with an enable, a packed alpha word and a colour-key enable. All of these are held steady by the surrounding register logic. The block works out the inclusive far corner itself. Window 0 is the base plane. It has no alpha and no colour key, so it always reports full opacity and a cleared key enable. The outputs are registered once, so the result for a coordinate appears one clock after that coordinate is presented.

Top module: `ovl_win_match`

## Requirements
- R1: Windows are numbered 0 to 4, and `sel_win_o` carries the 3-bit binary index of the selected window.
- R2: The far corner of a window on each axis is origin + size - 1, computed with a carry so that it never wraps. When origin + size is zero, the corner is 0, so a zero-size window at the origin still covers pixel 0. A zero-size window at a non-zero origin covers nothing.
- R3: When several enabled windows cover a pixel, the window with the highest index is selected.
- R4: A pixel is covered when origin_x <= x <= corner_x and origin_y <= y <= corner_y. Both edges are inclusive, and one pixel past either far edge is not covered.
- R5: When window 0 is selected, all three alpha outputs read 0xF and `ckey_en_o` reads 0, whatever its alpha and key inputs hold.
- R6: A window whose bit in `win_en_i` is 0 is never selected, even when it covers the pixel.
- R7: On a miss, `win_hit_o`, `sel_win_o`, the alpha outputs and `ckey_en_o` are 0 and `bg_rgb_o` equals `bg_rgb_i`. On a hit, `bg_rgb_o` is 0.
- R8: For windows 1 to 4, the alpha outputs come from `win_alpha_i[i*12 +: 12]`, with red in bits [11:8], green in [7:4] and blue in [3:0]. `ckey_en_o` equals `win_ckey_en_i[i]`.
- R9: All outputs are registered one clock after the coordinate and configuration inputs, and they read 0 while `rst_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_x_i | input | 12 | Current pixel column |
| pix_y_i | input | 12 | Current pixel row |
| win_en_i | input | 5 | Per-window enable, bit i for window i |
| win_ckey_en_i | input | 5 | Per-window colour-key enable, ignored for window 0 |
| win_off_x_i | input | 60 | Window origin X, 12 bits per window |
| win_off_y_i | input | 60 | Window origin Y, 12 bits per window |
| win_size_x_i | input | 60 | Window width, 12 bits per window |
| win_size_y_i | input | 60 | Window height, 12 bits per window |
| win_alpha_i | input | 60 | Window alpha, 12 bits per window as R,G,B nibbles |
| bg_rgb_i | input | 24 | Background colour used on a miss |
| win_hit_o | output | 1 | A window covers the pixel |
| sel_win_o | output | 3 | Index of the selected window |
| alpha_r_o | output | 4 | Red blend factor |
| alpha_g_o | output | 4 | Green blend factor |
| alpha_b_o | output | 4 | Blue blend factor |
| ckey_en_o | output | 1 | Colour-key enable of the selected window |
| bg_rgb_o | output | 24 | Background colour on a miss, else 0 |

## Verification
Every output is due exactly one rising edge after the coordinate and configuration that produced it. The bench therefore changes inputs on a falling edge, lets one rising edge pass, and samples on the following falling edge. A dedicated latency test samples just before and just after that edge, to show that the old result holds until the edge and the new one appears right after it. Configuration and coordinate are always changed together, so each check depends on a single registered step.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int unsigned ALPHA_W = 4;
  localparam int unsigned RGB_W   = 24;

  typedef struct packed {
    logic [ALPHA_W-1:0] r;
    logic [ALPHA_W-1:0] g;
    logic [ALPHA_W-1:0] b;
  } alpha_t;

  localparam int unsigned ALPHA_PACK_W = $bits(alpha_t);
  localparam alpha_t ALPHA_OPAQUE = '{r: '1, g: '1, b: '1};
endpackage

// File: rtl/ovl_corner.sv
module ovl_corner #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] off_i,
  input  logic [CW-1:0] size_i,
  output logic [CW:0]   last_o
);
  logic [CW:0] sum;

  assign sum    = {1'b0, off_i} + {1'b0, size_i};
  assign last_o = (sum == '0) ? '0 : sum - 1'b1;

  // zero-sized window at origin saturates to corner 0
  p_corner_sat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_i == '0 && size_i == '0) |-> last_o == '0);

  p_corner_span_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i != '0) |-> (last_o >= {1'b0, off_i}));
endmodule

// File: rtl/ovl_hit.sv
module ovl_hit #(
  parameter int unsigned CW = 12
) (
  input  logic          en_i,
  input  logic [CW-1:0] x_i,
  input  logic [CW-1:0] y_i,
  input  logic [CW-1:0] x0_i,
  input  logic [CW-1:0] y0_i,
  input  logic [CW:0]   x1_i,
  input  logic [CW:0]   y1_i,
  output logic          hit_o
);
  logic in_x, in_y;

  assign in_x  = (x_i >= x0_i) && ({1'b0, x_i} <= x1_i);
  assign in_y  = (y_i >= y0_i) && ({1'b0, y_i} <= y1_i);
  assign hit_o = en_i && in_x && in_y;
endmodule

// File: rtl/ovl_prio.sv
module ovl_prio #(
  parameter int unsigned NW = 5,
  localparam int unsigned IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] hit_i,
  output logic          valid_o,
  output logic [IW-1:0] sel_o
);
  always_comb begin
    valid_o = 1'b0;
    sel_o   = '0;
    for (int i = 0; i < NW; i++) begin
      if (hit_i[i]) begin
        valid_o = 1'b1;
        sel_o   = IW'(i);
      end
    end
  end

  // selected window hits and nothing above it does
  p_grant_top_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((hit_i >> sel_o) == NW'(1)));

  p_no_grant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (hit_i == '0));
endmodule

// File: rtl/ovl_win_match.sv
module ovl_win_match
  import ovl_pkg::*;
#(
  parameter int unsigned NW = 5,
  parameter int unsigned CW = 12,
  localparam int unsigned IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CW-1:0]            pix_x_i,
  input  logic [CW-1:0]            pix_y_i,
  input  logic [NW-1:0]            win_en_i,
  input  logic [NW-1:0]            win_ckey_en_i,
  input  logic [NW*CW-1:0]         win_off_x_i,
  input  logic [NW*CW-1:0]         win_off_y_i,
  input  logic [NW*CW-1:0]         win_size_x_i,
  input  logic [NW*CW-1:0]         win_size_y_i,
  input  logic [NW*ALPHA_PACK_W-1:0] win_alpha_i,
  input  logic [RGB_W-1:0]         bg_rgb_i,
  output logic                     win_hit_o,
  output logic [IW-1:0]            sel_win_o,
  output logic [ALPHA_W-1:0]       alpha_r_o,
  output logic [ALPHA_W-1:0]       alpha_g_o,
  output logic [ALPHA_W-1:0]       alpha_b_o,
  output logic                     ckey_en_o,
  output logic [RGB_W-1:0]         bg_rgb_o
);
  logic [NW-1:0] hit;
  alpha_t        win_alpha [NW];

  for (genvar i = 0; i < NW; i++) begin : g_win
    logic [CW:0] last_x, last_y;

    ovl_corner #(.CW(CW)) i_corner_x (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .off_i (win_off_x_i[i*CW +: CW]),
      .size_i(win_size_x_i[i*CW +: CW]),
      .last_o(last_x)
    );

    ovl_corner #(.CW(CW)) i_corner_y (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .off_i (win_off_y_i[i*CW +: CW]),
      .size_i(win_size_y_i[i*CW +: CW]),
      .last_o(last_y)
    );

    ovl_hit #(.CW(CW)) i_hit (
      .en_i (win_en_i[i]),
      .x_i  (pix_x_i),
      .y_i  (pix_y_i),
      .x0_i (win_off_x_i[i*CW +: CW]),
      .y0_i (win_off_y_i[i*CW +: CW]),
      .x1_i (last_x),
      .y1_i (last_y),
      .hit_o(hit[i])
    );

    // base plane has no blend or key capability
    if (i == 0) begin : g_base
      assign win_alpha[i] = ALPHA_OPAQUE;
    end else begin : g_ovl
      assign win_alpha[i] = alpha_t'(win_alpha_i[i*ALPHA_PACK_W +: ALPHA_PACK_W]);
    end
  end

  logic          any_hit;
  logic [IW-1:0] sel;

  ovl_prio #(.NW(NW)) i_prio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .valid_o(any_hit),
    .sel_o  (sel)
  );

  alpha_t alpha_d;
  logic   ckey_d;

  always_comb begin
    alpha_d = '0;
    ckey_d  = 1'b0;
    if (any_hit) begin
      for (int i = 0; i < NW; i++) begin
        if (sel == IW'(i)) begin
          alpha_d = win_alpha[i];
          ckey_d  = (i != 0) && win_ckey_en_i[i];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_hit_o <= 1'b0;
      sel_win_o <= '0;
      alpha_r_o <= '0;
      alpha_g_o <= '0;
      alpha_b_o <= '0;
      ckey_en_o <= 1'b0;
      bg_rgb_o  <= '0;
    end else begin
      win_hit_o <= any_hit;
      sel_win_o <= sel;
      alpha_r_o <= alpha_d.r;
      alpha_g_o <= alpha_d.g;
      alpha_b_o <= alpha_d.b;
      ckey_en_o <= ckey_d;
      bg_rgb_o  <= any_hit ? '0 : bg_rgb_i;
    end
  end

  p_base_opaque_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_hit_o && sel_win_o == '0) |->
      (alpha_r_o == '1 && alpha_g_o == '1 && alpha_b_o == '1 && !ckey_en_o));

  p_sel_enabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_hit_o |-> ((($past(win_en_i) >> sel_win_o) & NW'(1)) != '0));

  p_bg_on_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !win_hit_o) |-> (bg_rgb_o == $past(bg_rgb_i)));

  p_bg_on_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_hit_o |-> (bg_rgb_o == '0));

  p_sel_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_hit_o |-> (sel_win_o < IW'(NW)));
endmodule

// File: tb/test_ovl_win_match.sv
module test_ovl_win_match;
  localparam int NW = 5;
  localparam int CW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [CW-1:0]   px = '0, py = '0;
  logic [NW-1:0]   en = '0, ck = '0;
  logic [NW*CW-1:0] ox = '0, oy = '0, sx = '0, sy = '0;
  logic [NW*12-1:0] al = '0;
  logic [23:0]     bg = 24'h123456;
  logic            hit_o, ck_o;
  logic [2:0]      sel_o;
  logic [3:0]      ar, ag, ab;
  logic [23:0]     bg_o;
  int              n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  ovl_win_match i_ovl_win_match (
    .clk_i(clk), .rst_ni(rst_n), .pix_x_i(px), .pix_y_i(py),
    .win_en_i(en), .win_ckey_en_i(ck), .win_off_x_i(ox), .win_off_y_i(oy),
    .win_size_x_i(sx), .win_size_y_i(sy), .win_alpha_i(al), .bg_rgb_i(bg),
    .win_hit_o(hit_o), .sel_win_o(sel_o), .alpha_r_o(ar), .alpha_g_o(ag),
    .alpha_b_o(ab), .ckey_en_o(ck_o), .bg_rgb_o(bg_o)
  );

  task automatic chk(string req, logic h, logic [2:0] s, logic [11:0] a,
                     logic c, logic [23:0] b);
    n_chk++;
    if (hit_o !== h || sel_o !== s || {ar, ag, ab} !== a || ck_o !== c || bg_o !== b) begin
      n_fail++;
      $display("FAIL %s: got hit=%b sel=%0d a=%h ck=%b bg=%h exp hit=%b sel=%0d a=%h ck=%b bg=%h",
               req, hit_o, sel_o, {ar, ag, ab}, ck_o, bg_o, h, s, a, c, b);
    end
  endtask

  task automatic cfg(int i, logic e, int x0, int y0, int w, int h, logic [11:0] a, logic k);
    en[i] = e; ck[i] = k; al[i*12 +: 12] = a;
    ox[i*CW +: CW] = CW'(x0); oy[i*CW +: CW] = CW'(y0);
    sx[i*CW +: CW] = CW'(w);  sy[i*CW +: CW] = CW'(h);
  endtask

  task automatic at(int x, int y);
    px = CW'(x); py = CW'(y);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9 reset", 0, 0, 12'h000, 0, 24'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_background;
    @(negedge clk);
    at(10, 10);
    chk("R7 miss", 0, 0, 12'h000, 0, 24'h123456);
    bg = 24'hABCDEF;
    at(3000, 2000);
    chk("R7 miss new bg", 0, 0, 12'h000, 0, 24'hABCDEF);
  endtask

  task automatic t_single;
    @(negedge clk);
    cfg(2, 1, 100, 50, 20, 10, 12'hA5C, 1);
    at(100, 50);  chk("R8 R4 top-left", 1, 2, 12'hA5C, 1, 24'h0);
    at(119, 59);  chk("R4 bottom-right", 1, 2, 12'hA5C, 1, 24'h0);
    at(120, 59);  chk("R4 past x", 0, 0, 12'h000, 0, 24'hABCDEF);
    at(119, 60);  chk("R4 past y", 0, 0, 12'h000, 0, 24'hABCDEF);
    at(99, 50);   chk("R4 before x", 0, 0, 12'h000, 0, 24'hABCDEF);
  endtask

  task automatic t_priority;
    @(negedge clk);
    cfg(1, 1, 0, 0, 200, 200, 12'h321, 0);
    at(105, 55);  chk("R3 win2 over win1", 1, 2, 12'hA5C, 1, 24'h0);
    at(5, 5);     chk("R8 win1 alone", 1, 1, 12'h321, 0, 24'h0);
    cfg(4, 1, 104, 54, 2, 2, 12'h777, 0);
    at(105, 55);  chk("R3 R1 win4 top", 1, 4, 12'h777, 0, 24'h0);
  endtask

  task automatic t_disable;
    @(negedge clk);
    en[4] = 1'b0;
    at(105, 55);  chk("R6 win4 off", 1, 2, 12'hA5C, 1, 24'h0);
    en[2] = 1'b0;
    at(105, 55);  chk("R6 win2 off", 1, 1, 12'h321, 0, 24'h0);
  endtask

  task automatic t_base;
    @(negedge clk);
    en[1] = 1'b0;
    cfg(0, 1, 0, 0, 640, 480, 12'h123, 1);
    at(300, 300); chk("R5 base opaque", 1, 0, 12'hFFF, 0, 24'h0);
    en[1] = 1'b1;
    at(5, 5);     chk("R3 win1 over base", 1, 1, 12'h321, 0, 24'h0);
    at(300, 300); chk("R5 base outside win1", 1, 0, 12'hFFF, 0, 24'h0);
  endtask

  task automatic t_corner;
    @(negedge clk);
    en = '0;
    cfg(3, 1, 0, 0, 0, 0, 12'h456, 1);
    at(0, 0);     chk("R2 zero at origin", 1, 3, 12'h456, 1, 24'h0);
    at(1, 0);     chk("R2 zero at origin x1", 0, 0, 12'h000, 0, 24'hABCDEF);
    cfg(3, 1, 10, 10, 0, 0, 12'h456, 1);
    at(10, 10);   chk("R2 zero size offset", 0, 0, 12'h000, 0, 24'hABCDEF);
    cfg(3, 1, 4000, 0, 200, 1, 12'h456, 0);
    at(4095, 0);  chk("R2 no wrap", 1, 3, 12'h456, 0, 24'h0);
    at(3999, 0);  chk("R2 before wide", 0, 0, 12'h000, 0, 24'hABCDEF);
  endtask

  task automatic t_latency;
    @(negedge clk);
    px = CW'(4050); py = '0;
    @(posedge clk); #1;
    chk("R9 hit after one edge", 1, 3, 12'h456, 0, 24'h0);
    @(negedge clk);
    px = CW'(10);
    #4;
    chk("R9 held before edge", 1, 3, 12'h456, 0, 24'h0);
    @(posedge clk); #1;
    chk("R9 miss after edge", 0, 0, 12'h000, 0, 24'hABCDEF);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_background();
    t_single();
    t_priority();
    t_disable();
    t_base();
    t_corner();
    t_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule